// File: doc/BRIEF.md
# Synaptic Weight Updater with Deferred Grid Snapping

This block holds a bank of synaptic weights and applies the backpropagation delta rule to them, one weight per clock. Each weight's change is the product of a learning rate, the local gradient of the receiving neuron and the output of the sending neuron. The change is added to the stored weight, and the sum saturates rather than wraps. The block also keeps a training-iteration counter. Once that counter has climbed past a programmable threshold, every updated weight is also snapped onto a coarse grid with ten fractional bits.

A host first pulses the configuration strobe, which loads the learning rate and the threshold and clears the counter. For each training iteration the host pulses `start`. The block then walks the bank in index order and shows the index it is working on at `curIdx`. The host supplies the matching gradient and neuron output during that same cycle. A one-cycle `done` pulse follows the last write. Any weight can be read at any time through a combinational read port, and can be written through the same port while no pass is running.

Top module: `weight_trunc_updater`

## Requirements
- R1: After reset every weight reads 0, the iteration count is 0, and `busy` and `done` are low.
- R2: Weights, gradients and neuron outputs are signed 22-bit values with 20 fraction bits; the learning rate is signed 16-bit with 14 fraction bits. The change is (rate × gradient × output) shifted right arithmetically by 34 bits, which is floor rounding.
- R3: A pass updates weights 0 to N-1 in order, one per cycle. `curIdx` names the weight whose gradient and output are sampled at the next rising edge, and that weight becomes old value plus change.
- R4: A sum above 0x1FFFFF is stored as 0x1FFFFF, and a sum below -0x200000 is stored as -0x200000.
- R5: A configuration load clears the iteration count. Each accepted `start` adds one to it, before that pass's weights are written.
- R6: When the count is strictly greater than the threshold, each saturated result has its 10 lowest bits cleared, rounding toward zero: a negative value with nonzero low bits moves up by 0x400. When the count is at or below the threshold, the result is stored unchanged.
- R7: `busy` is high for exactly N cycles after an accepted `start`. `done` is high for the one cycle after the last weight write.
- R8: A host write takes effect only while no pass is running and is ignored during a pass. Reads return the addressed weight combinationally.
- R9: `start` is ignored while a pass is running; it neither restarts the pass nor changes the count.
- R10: A configuration load, accepted only while idle and taking priority over `start`, sets the learning rate and threshold used by later passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLoad | input | 1 | Load rate and threshold, clear iteration count |
| cfgRate | input | 16 | Signed learning rate, 14 fraction bits |
| cfgThresh | input | 8 | Iteration threshold for grid snapping |
| start | input | 1 | Begin one training pass |
| gradIn | input | 22 | Local gradient for weight `curIdx` |
| actIn | input | 22 | Sending neuron output for weight `curIdx` |
| curIdx | output | 3 | Index of the weight being updated |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse after the last write |
| iterCount | output | 8 | Training iteration count |
| hostWe | input | 1 | Host write enable |
| hostAddr | input | 3 | Host read/write address |
| hostWData | input | 22 | Host write data |
| hostRData | output | 22 | Weight at `hostAddr` |

## Verification
An accepted `start` raises `busy` and increments the count at the next rising edge. Weight k is written at the edge k+1 cycles after that, and `done` appears at edge N together with the return to idle. A host write shows at the read port right after its edge. The bench keeps a behavioural model that advances on each rising edge from the same inputs, and compares every output against it at the following falling edge, so each comparison sees the result of exactly the edges that have passed. Targeted reads at the end of a pass check the saturation, grid and ignored-write cases.

// File: rtl/wt_upd_pkg.sv
package wt_upd_pkg;

  typedef enum logic {
    ST_IDLE,
    ST_RUN
  } ctrlState_t;

  // Strobes from the sequencer to the arithmetic/storage side.
  typedef struct packed {
    logic wrEn;     // write the weight at the current index
    logic truncEn;  // snap the written value onto the coarse grid
    logic loadCfg;  // capture a new learning rate
  } ctrlStrobe_t;

endpackage

// File: rtl/wt_upd_ctrl.sv
module wt_upd_ctrl
  import wt_upd_pkg::*;
#(
  parameter int NUM_WEIGHTS = 8,
  parameter int CNT_W       = 8,
  localparam int IDX_W      = (NUM_WEIGHTS > 1) ? $clog2(NUM_WEIGHTS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             cfgLoad,
  input  logic [CNT_W-1:0] cfgThresh,
  output ctrlStrobe_t      strb,
  output logic [IDX_W-1:0] idx,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] iterCount
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_WEIGHTS - 1);

  ctrlState_t state;
  logic [CNT_W-1:0] threshReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      idx       <= '0;
      iterCount <= '0;
      threshReg <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cfgLoad) begin
            iterCount <= '0;
            threshReg <= cfgThresh;
          end else if (start) begin
            iterCount <= iterCount + 1'b1;
            idx       <= '0;
            state     <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (idx == LAST) begin
            idx   <= '0;
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy         = (state == ST_RUN);
  assign strb.wrEn    = busy;
  assign strb.truncEn = (iterCount > threshReg);
  assign strb.loadCfg = !busy && cfgLoad;

  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && idx == LAST) |=> (done && !busy));

  // R9
  busy_walk_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && idx != LAST) |=> (busy && idx == $past(idx) + 1'b1));

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && !cfgLoad) |=> (iterCount == $past(iterCount) + 1'b1));

  // R5
  count_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cfgLoad) |=> (iterCount == '0));

endmodule

// File: rtl/wt_upd_datapath.sv
module wt_upd_datapath
  import wt_upd_pkg::*;
#(
  parameter int NUM_WEIGHTS = 8,
  parameter int W_W         = 22,
  parameter int FRAC_W      = 20,
  parameter int KEEP_FRAC   = 10,
  parameter int LR_W        = 16,
  parameter int LR_FRAC     = 14,
  localparam int IDX_W      = (NUM_WEIGHTS > 1) ? $clog2(NUM_WEIGHTS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strb,
  input  logic [IDX_W-1:0] idx,
  input  logic [LR_W-1:0]  cfgRate,
  input  logic [W_W-1:0]   gradIn,
  input  logic [W_W-1:0]   actIn,
  input  logic             hostWe,
  input  logic [IDX_W-1:0] hostAddr,
  input  logic [W_W-1:0]   hostWData,
  output logic [W_W-1:0]   hostRData
);

  localparam int PROD_W = LR_W + 2 * W_W;
  localparam int SHIFT  = LR_FRAC + FRAC_W;
  localparam int DROP   = FRAC_W - KEEP_FRAC;
  localparam logic signed [W_W-1:0] WMAX = {1'b0, {(W_W-1){1'b1}}};
  localparam logic signed [W_W-1:0] WMIN = {1'b1, {(W_W-1){1'b0}}};
  localparam logic signed [PROD_W-1:0] WMAX_X = PROD_W'(WMAX);
  localparam logic signed [PROD_W-1:0] WMIN_X = PROD_W'(WMIN);
  localparam logic signed [W_W-1:0] GRID_STEP = W_W'(1) <<< DROP;

  logic [W_W-1:0] wMem [NUM_WEIGHTS];
  logic signed [LR_W-1:0] rateReg;

  logic signed [PROD_W-1:0] rateX, gradX, actX, prod, delta, oldX, sumX;
  logic signed [W_W-1:0] satW, clearedW, gridW, nextW;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rateReg <= '0;
    else if (strb.loadCfg) rateReg <= $signed(cfgRate);
  end

  // Three-way product, rescaled back to the weight's fraction width.
  always_comb begin
    rateX = PROD_W'(rateReg);
    gradX = PROD_W'($signed(gradIn));
    actX  = PROD_W'($signed(actIn));
    prod  = rateX * gradX * actX;
    delta = prod >>> SHIFT;
    oldX  = PROD_W'($signed(wMem[idx]));
    sumX  = oldX + delta;
  end

  // Clamp to the representable range.
  always_comb begin
    if (sumX > WMAX_X)      satW = WMAX;
    else if (sumX < WMIN_X) satW = WMIN;
    else                    satW = sumX[W_W-1:0];
  end

  // Snap to the coarse grid, rounding toward zero.
  always_comb begin
    clearedW = {satW[W_W-1:DROP], {DROP{1'b0}}};
    if (satW[W_W-1] && (satW[DROP-1:0] != '0)) gridW = clearedW + GRID_STEP;
    else                                       gridW = clearedW;
    nextW = strb.truncEn ? gridW : satW;
  end

  for (genvar g = 0; g < NUM_WEIGHTS; g++) begin : gBank
    logic updHit, hostHit;
    assign updHit  = strb.wrEn && (idx == IDX_W'(g));
    assign hostHit = hostWe && !strb.wrEn && (hostAddr == IDX_W'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        wMem[g] <= '0;
      else if (updHit)  wMem[g] <= nextW;
      else if (hostHit) wMem[g] <= hostWData;
    end
  end

  always_comb begin
    if (int'(hostAddr) < NUM_WEIGHTS) hostRData = wMem[hostAddr];
    else                              hostRData = '0;
  end

  // R6
  trunc_grid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.truncEn) |=> (wMem[$past(idx)][DROP-1:0] == '0));

  // R4
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && !strb.truncEn && $signed(wMem[idx]) == WMAX && delta >= 0)
      |=> ($signed(wMem[$past(idx)]) == WMAX));

  // R8
  host_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && hostWe && hostAddr != idx)
      |=> (wMem[$past(hostAddr)] == $past(wMem[hostAddr])));

endmodule

// File: rtl/weight_trunc_updater.sv
module weight_trunc_updater
  import wt_upd_pkg::*;
#(
  parameter int NUM_WEIGHTS = 8,
  parameter int W_W         = 22,
  parameter int FRAC_W      = 20,
  parameter int KEEP_FRAC   = 10,
  parameter int LR_W        = 16,
  parameter int LR_FRAC     = 14,
  parameter int CNT_W       = 8,
  localparam int IDX_W      = (NUM_WEIGHTS > 1) ? $clog2(NUM_WEIGHTS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgLoad,
  input  logic [LR_W-1:0]  cfgRate,
  input  logic [CNT_W-1:0] cfgThresh,
  input  logic             start,
  input  logic [W_W-1:0]   gradIn,
  input  logic [W_W-1:0]   actIn,
  output logic [IDX_W-1:0] curIdx,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] iterCount,
  input  logic             hostWe,
  input  logic [IDX_W-1:0] hostAddr,
  input  logic [W_W-1:0]   hostWData,
  output logic [W_W-1:0]   hostRData
);

  ctrlStrobe_t strb;

  wt_upd_ctrl #(
    .NUM_WEIGHTS(NUM_WEIGHTS),
    .CNT_W      (CNT_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .cfgLoad  (cfgLoad),
    .cfgThresh(cfgThresh),
    .strb     (strb),
    .idx      (curIdx),
    .busy     (busy),
    .done     (done),
    .iterCount(iterCount)
  );

  wt_upd_datapath #(
    .NUM_WEIGHTS(NUM_WEIGHTS),
    .W_W        (W_W),
    .FRAC_W     (FRAC_W),
    .KEEP_FRAC  (KEEP_FRAC),
    .LR_W       (LR_W),
    .LR_FRAC    (LR_FRAC)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .idx      (curIdx),
    .cfgRate  (cfgRate),
    .gradIn   (gradIn),
    .actIn    (actIn),
    .hostWe   (hostWe),
    .hostAddr (hostAddr),
    .hostWData(hostWData),
    .hostRData(hostRData)
  );

endmodule

// File: tb/weight_trunc_updater_test.sv
module weight_trunc_updater_test;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgLoad = 1'b0;
  logic [15:0] cfgRate = '0;
  logic [7:0]  cfgThresh = '0;
  logic        start = 1'b0;
  logic [21:0] gradIn = '0;
  logic [21:0] actIn = '0;
  logic [2:0]  curIdx;
  logic        busy, done;
  logic [7:0]  iterCount;
  logic        hostWe = 1'b0;
  logic [2:0]  hostAddr = '0;
  logic [21:0] hostWData = '0;
  logic [21:0] hostRData;

  weight_trunc_updater uut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgRate(cfgRate),
    .cfgThresh(cfgThresh), .start(start), .gradIn(gradIn), .actIn(actIn),
    .curIdx(curIdx), .busy(busy), .done(done), .iterCount(iterCount),
    .hostWe(hostWe), .hostAddr(hostAddr), .hostWData(hostWData),
    .hostRData(hostRData)
  );

  always #5 clk = ~clk;

  int nChk = 0, nFail = 0, cyc = 0, passNo = 0;
  bit compareOn = 0;

  // Behavioural reference state.
  int mW[N];
  int mRate = 0, mQ = 0, mCnt = 0, mIdx = 0;
  bit mBusy = 0, mDone = 0;

  function automatic int stepW(int w, int g, int a, int r, bit tr);
    longint p, s;
    p = longint'(r) * longint'(g) * longint'(a);
    s = longint'(w) + (p >>> 34);
    if (s > 64'sd2097151) s = 2097151;
    if (s < -64'sd2097152) s = -2097152;
    if (tr) s = (s / 1024) * 1024;
    return int'(s);
  endfunction

  function automatic int gradOf(int p, int i);
    case (i)
      0: return (p == 1) ? 32'h40000 : ((p * 40503 + 7) % 65536) - 32768;
      1: return 32'h0FFFFF;
      2: return -32'h0FFFFF;
      3: return 32'h40;
      4: return -32'h40;
      default: return ((p * 40503 + i * 9973) % 65536) - 32768;
    endcase
  endfunction

  function automatic int actOf(int p, int i);
    case (i)
      0: return (p == 1) ? 32'h80000 : ((p * 2654 + 5) % 262144) - 131072;
      1, 2: return 32'h0FFFFF;
      3, 4: return 32'h100000;
      default: return ((p * 2654 + i * 911) % 262144) - 131072;
    endcase
  endfunction

  always @(posedge clk) begin
    bit dn;
    if (!rstN) begin
      foreach (mW[k]) mW[k] = 0;
      mRate = 0; mQ = 0; mCnt = 0; mIdx = 0; mBusy = 0; mDone = 0;
    end else begin
      dn = 0;
      if (mBusy) begin
        mW[mIdx] = stepW(mW[mIdx], int'($signed(gradIn)), int'($signed(actIn)),
                         mRate, mCnt > mQ);
        if (mIdx == N - 1) begin mBusy = 0; mIdx = 0; dn = 1; end
        else mIdx = mIdx + 1;
      end else begin
        if (hostWe) mW[hostAddr] = int'($signed(hostWData));
        if (cfgLoad) begin
          mRate = int'($signed(cfgRate)); mQ = int'(cfgThresh); mCnt = 0;
        end else if (start) begin
          mCnt = (mCnt + 1) & 255; mBusy = 1; mIdx = 0;
        end
      end
      mDone = dn;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h) at cycle %0d",
               req, act, act, exp, exp, cyc);
    end
  endtask

  task automatic compareAll();
    check(busy == mBusy, "R7 busy", int'(busy), int'(mBusy));
    check(done == mDone, "R7 done", int'(done), int'(mDone));
    check(int'(iterCount) == mCnt, "R5 count", int'(iterCount), mCnt);
    if (mBusy) check(int'(curIdx) == mIdx, "R3 index", int'(curIdx), mIdx);
    check(int'($signed(hostRData)) == mW[hostAddr], "R3 weight",
          int'($signed(hostRData)), mW[hostAddr]);
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (compareOn) compareAll();
    start = 0; cfgLoad = 0; hostWe = 0;
    hostAddr = 3'(cyc % N);
    gradIn = 22'(gradOf(passNo, int'(curIdx)));
    actIn  = 22'(actOf(passNo, int'(curIdx)));
  endtask

  function automatic int readW(int a);
    return int'($signed(uut.hostRData));
  endfunction

  task automatic peek(int a, output int v);
    hostAddr = 3'(a);
    #1;
    v = int'($signed(hostRData));
  endtask

  task automatic runPass(bit disturb);
    passNo++;
    start = 1;
    tick();
    for (int k = 0; k < N; k++) begin
      if (disturb && k == 3) begin
        start = 1; hostWe = 1; hostAddr = 3'd5; hostWData = 22'h15555;
      end
      tick();
    end
    check(done == 1'b1, "R7 done after pass", int'(done), 1);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int v, w5;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 0 && done == 0, "R1 flags", int'({busy, done}), 0);
    check(iterCount == 0, "R1 count", int'(iterCount), 0);
    for (int a = 0; a < N; a++) begin
      peek(a, v);
      check(v == 0, "R1 weight", v, 0);
    end
    rstN = 1;
    compareOn = 1;
    tick();

    // R10 configuration: rate 0.5, threshold 2
    cfgRate = 16'h2000; cfgThresh = 8'd2; cfgLoad = 1;
    tick();
    hostWe = 1; hostAddr = 3'd1; hostWData = 22'h1F0000;
    tick();
    hostWe = 1; hostAddr = 3'd2; hostWData = 22'(-32'h1F0000);
    tick();

    runPass(0);
    peek(0, v); check(v == 32'h10000, "R2 product", v, 32'h10000);
    peek(1, v); check(v == 32'h1FFFFF, "R4 clamp high", v, 32'h1FFFFF);
    peek(2, v); check(v == -32'h200000, "R4 clamp low", v, -32'h200000);
    peek(3, v); check(v == 32'h20, "R3 accumulate", v, 32'h20);
    check(iterCount == 1, "R5 count pass1", int'(iterCount), 1);
    tick();

    peek(5, w5);
    runPass(1);
    check(iterCount == 2, "R9 start ignored", int'(iterCount), 2);
    peek(5, v); check(v != 32'h15555 && v == mW[5], "R8 busy write ignored", v, mW[5]);
    peek(3, v); check(v == 32'h40, "R6 count equals threshold", v, 32'h40);
    tick();

    runPass(0);
    peek(3, v); check(v == 0, "R6 positive snap", v, 0);
    peek(4, v); check(v == 0, "R6 toward zero", v, 0);
    peek(1, v); check(v == 32'h1FFC00, "R6 snapped clamp", v, 32'h1FFC00);
    for (int a = 0; a < N; a++) begin
      peek(a, v);
      check((v & 1023) == 0, "R6 grid", v & 1023, 0);
    end
    tick();
    runPass(0);
    tick();

    hostWe = 1; hostAddr = 3'd6; hostWData = 22'h2AA55;
    tick();
    peek(6, v); check(v == 32'h2AA55, "R8 idle write", v, 32'h2AA55);

    cfgRate = 16'h0000; cfgThresh = 8'd10; cfgLoad = 1; start = 1;
    tick();
    check(iterCount == 0 && busy == 0, "R10 load wins, R5 cleared", int'(iterCount), 0);
    runPass(0);
    peek(6, v); check(v == 32'h2AA55, "R10 zero rate", v, 32'h2AA55);
    check(iterCount == 1, "R5 count after reload", int'(iterCount), 1);
    tick();
    tick();
    finishRun();
  end

endmodule